// File: doc/BRIEF.md
# System Clock Prescaler with Machine-Cycle Divider

This block turns oscillator activity into two clock enables that a small controller core runs from. All logic runs on one fast reference clock. Each of three oscillator sources (a main oscillator, an internal ring oscillator and a low-speed sub-clock) is represented by a one-cycle tick input on that reference clock. A 4-bit mode word, written through a simple write strobe, selects which source ticks are counted and how many of them form one system-clock period (1, 2, 4 or 8). A separate flag, written with the mode word, chooses between the main and ring oscillators when the sub-clock is not selected.

Every system-clock period ends with a single-cycle system enable. A fixed divide-by-three stage counts those enables and emits an instruction enable on every third one, marking the end of a machine cycle; a 2-bit phase output reports how many system enables of the current machine cycle have elapsed. A new mode is held pending and only takes over when the period that is running completes, so no period is ever cut short or stretched by a write.

Top module: `sysclk_presc`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `sys_en` and `inst_en` are 0 and `phase` is 0; after reset the active setting is the ring oscillator with a period of 8 ticks.
- R2: Mode bits [3:2] set the period in source ticks: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 8.
- R3: When mode bit 0 is 1 the sub-clock (`ref_sub`) is the source, whatever the value of bit 1.
- R4: When mode bit 0 is 0 the source is the main oscillator (`ref_main`) if `wr_use_main` was 1 at the write, otherwise the ring oscillator (`ref_ring`); mode bit 1 has no effect.
- R5: A written mode takes effect only once the period in progress completes under the old mode; a write never ends or extends the running period.
- R6: `sys_en` is high for exactly one cycle, in the cycle after the reference edge at which the selected source delivers the tick that completes the period.
- R7: `inst_en` is high together with every third `sys_en` pulse and never without `sys_en`.
- R8: `phase` steps 0, 1, 2 at each `sys_en` pulse and returns to 0 in the cycle that `inst_en` is high; it holds its value between pulses.
- R9: Ticks on the two unselected source inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_main | input | 1 | One-cycle tick of the main oscillator |
| ref_ring | input | 1 | One-cycle tick of the ring oscillator |
| ref_sub | input | 1 | One-cycle tick of the low-speed sub-clock |
| wr_en | input | 1 | Write strobe for the mode word |
| wr_mode | input | 4 | Mode word: [3:2] divide code, [0] sub-clock select, [1] unused |
| wr_use_main | input | 1 | With bit 0 clear, 1 picks the main oscillator, 0 the ring |
| sys_en | output | 1 | System-clock enable pulse |
| inst_en | output | 1 | Instruction-clock (machine cycle) enable pulse |
| phase | output | 2 | System enables elapsed in the current machine cycle |

## Verification
The hardest case is a mode write landing in the middle of a long period, for example switching away from the slow sub-clock with several of its ticks still outstanding, where the old ratio and old source must keep governing until the boundary. The stimulus reaches it by issuing writes at uneven times while the three sources tick at different rates (one random, two periodic with unrelated periods), so writes fall at every count position; a cycle-accurate behavioural model tracks the pending and active settings and flags any early or late pulse. Dense ticks on the unselected sources while the sub-clock is active cover the isolation of the inputs.

// File: rtl/sysclk_presc_pkg.sv
package sysclk_presc_pkg;

    localparam int MODE_W   = 4;
    localparam int DIV_W    = 2;
    localparam int NSRC     = 3;
    localparam int MAX_DIV  = (1 << ((1 << DIV_W) - 1));
    localparam int CNT_W    = $clog2(MAX_DIV);
    localparam int INST_DIV = 3;
    localparam int PH_W     = $clog2(INST_DIV + 1);

    typedef enum logic [1:0] {
        SRC_RING = 2'd0,
        SRC_MAIN = 2'd1,
        SRC_SUB  = 2'd2
    } src_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        src_e             src;
    } clk_cfg_t;

    localparam clk_cfg_t CFG_RESET = '{div: {DIV_W{1'b1}}, src: SRC_RING};

    // Divide code and sub-clock bit plus main/ring flag into a setting.
    function automatic clk_cfg_t decode_mode(logic [DIV_W-1:0] div_code,
                                             logic sub_bit,
                                             logic use_main);
        clk_cfg_t c;
        c.div = div_code;
        if (sub_bit)
            c.src = SRC_SUB;
        else if (use_main)
            c.src = SRC_MAIN;
        else
            c.src = SRC_RING;
        return c;
    endfunction

    // Count value of the last source tick in a period.
    function automatic logic [CNT_W-1:0] last_count(logic [DIV_W-1:0] div_code);
        return CNT_W'((1 << div_code) - 1);
    endfunction

endpackage

// File: rtl/sysclk_mode_reg.sv
module sysclk_mode_reg
    import sysclk_presc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_mode,
    input  logic              wr_use_main,
    input  logic              commit,
    output clk_cfg_t          active_cfg
);

    clk_cfg_t pending_q;
    clk_cfg_t active_q;
    clk_cfg_t wr_cfg;

    logic unused_mode_bit1;
    assign unused_mode_bit1 = wr_mode[1];

    always_comb begin
        wr_cfg = decode_mode(wr_mode[MODE_W-1 -: DIV_W], wr_mode[0], wr_use_main);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= CFG_RESET;
            active_q  <= CFG_RESET;
        end else begin
            if (wr_en)
                pending_q <= wr_cfg;
            if (commit)
                active_q <= pending_q;
        end
    end

    assign active_cfg = active_q;

endmodule

// File: rtl/sysclk_src_div.sv
module sysclk_src_div
    import sysclk_presc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_ticks,
    input  clk_cfg_t        cfg,
    output logic            period_end,
    output logic            sys_en
);

    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic [NSRC-1:0]  sel_onehot;

    genvar gi;
    generate
        for (gi = 0; gi < NSRC; gi++) begin : g_sel
            assign sel_onehot[gi] = (cfg.src == src_e'(gi)) && src_ticks[gi];
        end
    endgenerate

    assign tick       = |sel_onehot;
    assign period_end = tick && (cnt_q == last_count(cfg.div));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            sys_en <= 1'b0;
        end else begin
            sys_en <= period_end;
            if (period_end)
                cnt_q <= '0;
            else if (tick)
                cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sysclk_cycle_div.sv
module sysclk_cycle_div
    import sysclk_presc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    output logic            inst_en,
    output logic [PH_W-1:0] phase
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(INST_DIV - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= '0;
            inst_en <= 1'b0;
        end else begin
            inst_en <= 1'b0;
            if (step) begin
                if (phase == PH_LAST) begin
                    phase   <= '0;
                    inst_en <= 1'b1;
                end else begin
                    phase <= phase + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sysclk_presc.sv
module sysclk_presc
    import sysclk_presc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ref_main,
    input  logic        ref_ring,
    input  logic        ref_sub,
    input  logic        wr_en,
    input  logic [3:0]  wr_mode,
    input  logic        wr_use_main,
    output logic        sys_en,
    output logic        inst_en,
    output logic [1:0]  phase
);

    clk_cfg_t        active_cfg;
    logic            period_end;
    logic [NSRC-1:0] src_ticks;

    always_comb begin
        src_ticks                 = '0;
        src_ticks[int'(SRC_RING)] = ref_ring;
        src_ticks[int'(SRC_MAIN)] = ref_main;
        src_ticks[int'(SRC_SUB)]  = ref_sub;
    end

    sysclk_mode_reg u_mode (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_mode     (wr_mode),
        .wr_use_main (wr_use_main),
        .commit      (period_end),
        .active_cfg  (active_cfg)
    );

    sysclk_src_div u_div (
        .clk        (clk),
        .rst        (rst),
        .src_ticks  (src_ticks),
        .cfg        (active_cfg),
        .period_end (period_end),
        .sys_en     (sys_en)
    );

    sysclk_cycle_div u_cyc (
        .clk     (clk),
        .rst     (rst),
        .step    (period_end),
        .inst_en (inst_en),
        .phase   (phase)
    );

endmodule

// File: rtl/sysclk_presc_chk.sv
module sysclk_presc_chk (
    input logic       clk,
    input logic       rst,
    input logic       ref_main,
    input logic       ref_ring,
    input logic       ref_sub,
    input logic       sys_en,
    input logic       inst_en,
    input logic [1:0] phase
);

    // R1: outputs idle right after a reset cycle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!sys_en && !inst_en && phase == 2'd0));

    // R6: a system enable follows some source tick
    a_r6_tick_before_sys: assert property (@(posedge clk) disable iff (rst)
        sys_en |-> $past(ref_main || ref_ring || ref_sub));

    // R7: machine-cycle enable only with a system enable
    a_r7_inst_with_sys: assert property (@(posedge clk) disable iff (rst)
        inst_en |-> sys_en);

    // R7: machine-cycle enables are never back to back
    a_r7_inst_spacing: assert property (@(posedge clk) disable iff (rst)
        inst_en |=> !inst_en);

    // R8: phase stays within the machine cycle
    a_r8_phase_range: assert property (@(posedge clk) disable iff (rst)
        phase != 2'd3);

    // R8: phase holds between system enables
    a_r8_phase_hold: assert property (@(posedge clk) disable iff (rst)
        !sys_en |-> $stable(phase));

    // R8: phase steps modulo three on each system enable
    a_r8_phase_step: assert property (@(posedge clk) disable iff (rst)
        sys_en |-> (phase == (($past(phase) == 2'd2) ? 2'd0 : $past(phase) + 2'd1)));

    // R8: wrap of phase coincides with the machine-cycle enable
    a_r8_wrap_inst: assert property (@(posedge clk) disable iff (rst)
        (sys_en && phase == 2'd0) |-> inst_en);

endmodule

bind sysclk_presc sysclk_presc_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .ref_main (ref_main),
    .ref_ring (ref_ring),
    .ref_sub  (ref_sub),
    .sys_en   (sys_en),
    .inst_en  (inst_en),
    .phase    (phase)
);

// File: tb/sysclk_presc_tb_top.sv
`timescale 1ns/1ps
module sysclk_presc_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_main = 1'b0;
    logic       ref_ring = 1'b0;
    logic       ref_sub = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_mode = 4'd0;
    logic       wr_use_main = 1'b0;
    logic       sys_en;
    logic       inst_en;
    logic [1:0] phase;

    always #2.5 clk = ~clk;

    sysclk_presc dut_i (
        .clk         (clk),
        .rst         (rst),
        .ref_main    (ref_main),
        .ref_ring    (ref_ring),
        .ref_sub     (ref_sub),
        .wr_en       (wr_en),
        .wr_mode     (wr_mode),
        .wr_use_main (wr_use_main),
        .sys_en      (sys_en),
        .inst_en     (inst_en),
        .phase       (phase)
    );

    int    errors = 0;
    int    checks = 0;
    int    cyc = 0;
    bit    done = 0;
    string tag = "R1";

    // tick pattern controls
    bit main_dense = 0;
    bit ring_dense = 0;

    // behavioural reference model (0 ring, 1 main, 2 sub)
    int pend_div = 3, pend_src = 0, act_div = 3, act_src = 0, m_cnt = 0;
    int exp_sys = 0, exp_inst = 0, exp_ph = 0;

    always @(posedge clk) begin
        int tk;
        int fire;
        if (rst) begin
            pend_div = 3; pend_src = 0; act_div = 3; act_src = 0;
            m_cnt = 0; exp_sys = 0; exp_inst = 0; exp_ph = 0;
        end else begin
            tk = (act_src == 2) ? int'(ref_sub) : (act_src == 1) ? int'(ref_main) : int'(ref_ring);
            fire = (tk != 0 && m_cnt == (1 << act_div) - 1) ? 1 : 0;
            exp_sys = fire;
            exp_inst = 0;
            if (fire != 0) begin
                m_cnt = 0;
                act_div = pend_div;
                act_src = pend_src;
                if (exp_ph == 2) begin exp_ph = 0; exp_inst = 1; end
                else exp_ph = exp_ph + 1;
            end else if (tk != 0) begin
                m_cnt = m_cnt + 1;
            end
            if (wr_en) begin
                pend_div = int'(wr_mode[3:2]);
                pend_src = wr_mode[0] ? 2 : (wr_use_main ? 1 : 0);
            end
        end
    end

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic compare_now();
        check(tag, int'(sys_en), exp_sys, "sys_en");
        check(tag, int'(inst_en), exp_inst, "inst_en");
        check(tag, int'(phase), exp_ph, "phase");
    endtask

    task automatic drive_refs();
        ref_main = main_dense ? 1'b1 : 1'($urandom % 2);
        ref_ring = ring_dense ? 1'b1 : ((cyc % 3) == 0);
        ref_sub  = ((cyc % 11) == 0);
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_now();
            drive_refs();
            wr_en = 1'b0;
        end
    endtask

    task automatic write_mode(logic [3:0] m, logic um);
        @(negedge clk);
        compare_now();
        drive_refs();
        wr_en = 1'b1;
        wr_mode = m;
        wr_use_main = um;
    endtask

    // counts pulses at the ports over a window
    task automatic count_pulses(int n, output int ns, output int ni);
        ns = 0; ni = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_now();
            drive_refs();
            wr_en = 1'b0;
            ns += int'(sys_en);
            ni += int'(inst_en);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int ns, ni;
        // R1: reset state
        tag = "R1";
        repeat (3) @(negedge clk);
        check("R1", int'(sys_en), 0, "sys_en in reset");
        check("R1", int'(inst_en), 0, "inst_en in reset");
        check("R1", int'(phase), 0, "phase in reset");
        rst = 1'b0;
        step(1);
        // R1: default is ring /8; ring every third cycle -> one pulse per 24 cycles
        step(60);
        count_pulses(240, ns, ni);
        check("R1", ns, 10, "ring/8 pulse count after reset");

        // R2: every divide code on a dense main source
        main_dense = 1;
        tag = "R2";
        for (int d = 0; d < 4; d++) begin
            write_mode({2'(d), 2'b00}, 1'b1);
            step(60);
            count_pulses(96, ns, ni);
            check("R2", ns, 96 >> d, "pulses per 96 dense ticks");
        end

        // R7: divide by 1 -> instruction enable every third cycle
        tag = "R7";
        write_mode(4'b0000, 1'b1);
        step(60);
        count_pulses(96, ns, ni);
        check("R7", ni, 32, "instruction enables per 96 system enables");

        // R3: sub-clock with bit 1 clear and set
        main_dense = 0;
        tag = "R3";
        write_mode(4'b0001, 1'b1);
        step(60);
        count_pulses(220, ns, ni);
        check("R3", ns, 20, "sub/1 pulses, bit1=0");
        write_mode(4'b0111, 1'b0);
        step(80);
        count_pulses(220, ns, ni);
        check("R3", ns, 10, "sub/2 pulses, bit1=1");

        // R9: unselected sources ticking every cycle change nothing
        tag = "R9";
        main_dense = 1;
        ring_dense = 1;
        write_mode(4'b0011, 1'b1);
        step(60);
        count_pulses(220, ns, ni);
        check("R9", ns, 20, "sub/1 pulses with busy main and ring");
        ring_dense = 0;

        // R4: bit 1 ignored, flag picks main vs ring
        tag = "R4";
        write_mode(4'b0110, 1'b0);
        step(60);
        count_pulses(240, ns, ni);
        check("R4", ns, 40, "ring/2 with bit1 set");
        write_mode(4'b0110, 1'b1);
        step(60);
        count_pulses(96, ns, ni);
        check("R4", ns, 48, "main/2 with bit1 set");

        // R5/R6: writes at uneven times against the cycle-accurate model
        main_dense = 0;
        tag = "R5";
        for (int k = 0; k < 200; k++) begin
            write_mode(4'($urandom), 1'($urandom % 2));
            step(1 + int'($urandom % 37));
        end
        tag = "R6";
        for (int k = 0; k < 60; k++) begin
            write_mode({2'($urandom), 2'b00}, 1'b1);
            step(1 + int'($urandom % 5));
        end
        step(100);

        // R8: phase after a fresh reset, then a run of steps
        tag = "R8";
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(1);
        check("R8", int'(phase), 0, "phase after reset");
        step(300);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule